// File: doc/BRIEF.md
# System Clock Source Switch Controller

This block decides which of three oscillators drives the system clock: the internal RC oscillator, the external crystal oscillator, or the PLL output. Software writes a target source. The controller changes the active selection only after that target is both enabled and stable. Until then the previous source stays active and a pending flag is shown.

Each source has an enable request from software and a stable indication from the analog side. The stable indications arrive asynchronously, so each one passes through a synchronizer first. The block drives the enable for each oscillator. It keeps an oscillator running whenever the active clock depends on it, either directly or as the PLL reference, even if software withdraws its enable request.

The selection is a register that changes on a synchronous handshake. A one-cycle done pulse marks each change of the active source. Gate-level glitch-free clock muxing is left to the clock gating cells downstream.

Top module: `sysclk_switch_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, the outputs take these values: `active_src` = 2'b00 (internal RC), `switch_pending` = 0, `switch_done` = 0, `irc_en` = 1, `xosc_en` = 0, `pll_en` = 0. The software enable requests are all low in this state.
- R2: Sources are coded 2'b00 for the internal RC, 2'b01 for the external oscillator and 2'b10 for the PLL. The same codes are used on `sw_sel` and on `active_src`. A request with code 2'b11 is ignored: the pending flag and the active source keep their values.
- R3: A switch happens only once the target source's enable output is high and its synchronized stable input is high. While this does not hold, `switch_pending` stays 1 and `active_src` keeps the previous source. A stable input is seen SYNC_STAGES clock edges after it rises, and the switch occurs on the next edge after that.
- R4: When the switch condition is met while a request is pending, `active_src` takes the target value on the next clock edge. In the same cycle `switch_done` is high, for exactly one cycle, and `switch_pending` drops to 0.
- R5: A new valid request replaces a pending one. Only the most recent target can become active.
- R6: A request for the PLL while `pll_en` is low stays pending indefinitely, and `active_src` is unchanged.
- R7: `irc_en` is held high while the internal RC is the active source. It is also held high while the PLL is active with the internal RC as its reference (`pll_ref_xosc` = 0). This holds whatever `sw_irc_en` is.
- R8: `xosc_en` is held high while the external oscillator is active. It is also held high while the PLL is active with `pll_ref_xosc` = 1. This holds whatever `sw_xosc_en` is.
- R9: `pll_en` is held high while the PLL is the active source, whatever `sw_pll_en` is.
- R10: A request naming the source that is already active clears `switch_pending` and produces no `switch_done` pulse.
- R11: Each enable output is the OR of its software request and its protection term, registered, so it follows a change one clock edge later. An enable whose source is not protected follows its software request, including to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_sel_valid | input | 1 | One-cycle strobe carrying a new target source request |
| sw_sel | input | 2 | Target source code (00 RC, 01 external, 10 PLL) |
| sw_irc_en | input | 1 | Software enable request for the internal RC |
| sw_xosc_en | input | 1 | Software enable request for the external oscillator |
| sw_pll_en | input | 1 | Software enable request for the PLL |
| pll_ref_xosc | input | 1 | PLL reference select: 0 internal RC, 1 external oscillator |
| irc_stable | input | 1 | Asynchronous stable indication of the internal RC |
| xosc_stable | input | 1 | Asynchronous stable indication of the external oscillator |
| pll_stable | input | 1 | Asynchronous stable (lock) indication of the PLL |
| irc_en | output | 1 | Effective enable of the internal RC |
| xosc_en | output | 1 | Effective enable of the external oscillator |
| pll_en | output | 1 | Effective enable of the PLL |
| active_src | output | 2 | Currently active system clock source code |
| switch_pending | output | 1 | A requested switch has not yet taken effect |
| switch_done | output | 1 | One-cycle pulse when the active source changes |

## Verification
The bench builds the block with its default synchronizer depth, SYNC_STAGES = 2. It computes the wait before a switch from that parameter. With this it can sample exactly the last cycle in which the old source is still active and the first cycle in which the new one is active. That reaches the stable-wait boundary of R3, and it also covers the PLL-reference protection cases: a request replaced while pending, and a PLL request refused for lack of an enable.

// File: rtl/sysclk_pkg.sv
// Package: sysclk_pkg
// Purpose : shared source codes and index constants for the system clock
//           switch controller.
// Assumes : exactly three selectable sources; codes are visible to software.
package sysclk_pkg;

    localparam int NUM_SRC = 3;
    localparam int SEL_W   = $clog2(NUM_SRC);

    // Source codes; the numeric value doubles as the bit index in vectors.
    typedef enum logic [SEL_W-1:0] {
        SRC_IRC  = 2'b00,
        SRC_XOSC = 2'b01,
        SRC_PLL  = 2'b10
    } src_e;

    localparam int IDX_IRC  = 0;
    localparam int IDX_XOSC = 1;
    localparam int IDX_PLL  = 2;

    // Value of the enable vector while in reset: only the internal RC runs.
    localparam logic [NUM_SRC-1:0] EN_RST = 3'b001;

    // A code is usable only if it names one of the sources.
    function automatic logic code_ok(input logic [SEL_W-1:0] code);
        return (int'(code) < NUM_SRC);
    endfunction

endpackage

// File: rtl/sysclk_stable_sync.sv
// Module : sysclk_stable_sync
// Purpose: brings the asynchronous stable indications into the controller
//          clock domain, one flop chain per source.
// Assumes: each stable input is a level that stays put for far longer than
//          STAGES clock periods; reset clears all chains (not stable).
module sysclk_stable_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain_q;

            // Shift the raw level through STAGES flops.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q <= '0;
                end else if (STAGES == 1) begin
                    chain_q <= async_in[b];
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], async_in[b]};
                end
            end

            assign sync_out[b] = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/sysclk_enable_guard.sv
// Module : sysclk_enable_guard
// Purpose: produces the registered oscillator enables as software request
//          OR a protection term that keeps alive whatever the active clock
//          depends on.
// Assumes: active source comes from the select register; the PLL reference
//          select is a quasi-static level.
module sysclk_enable_guard
    import sysclk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  src_e               active,
    input  logic               pll_ref_xosc,
    input  logic [NUM_SRC-1:0] sw_en,
    output logic [NUM_SRC-1:0] en_q
);

    logic [NUM_SRC-1:0] keep_on;
    logic               pll_live;

    // Work out which oscillators the current system clock relies on.
    always_comb begin
        pll_live          = (active == SRC_PLL);
        keep_on           = '0;
        keep_on[IDX_IRC]  = (active == SRC_IRC)  || (pll_live && !pll_ref_xosc);
        keep_on[IDX_XOSC] = (active == SRC_XOSC) || (pll_live &&  pll_ref_xosc);
        keep_on[IDX_PLL]  = pll_live;
    end

    // Register the effective enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= EN_RST;
        end else begin
            en_q <= sw_en | keep_on;
        end
    end

endmodule

// File: rtl/sysclk_select_fsm.sv
// Module : sysclk_select_fsm
// Purpose: holds the active source and one pending target; commits the
//          target once it is ready and pulses done for that cycle.
// Assumes: ready[i] already combines enable and synchronized stable; a
//          request strobe takes priority over a commit in the same cycle.
module sysclk_select_fsm
    import sysclk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [SEL_W-1:0]   req_sel,
    input  logic [NUM_SRC-1:0] ready,
    output src_e               active,
    output logic               pending,
    output logic               done
);

    src_e target_q;
    logic req_take;
    logic commit;

    // Classify this cycle: accept a request, or commit the pending one.
    always_comb begin
        req_take = req_valid && code_ok(req_sel);
        commit   = !req_take && pending && ready[target_q];
    end

    // Update the select register, pending target and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= SRC_IRC;
            target_q <= SRC_IRC;
            pending  <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (req_take) begin
                target_q <= src_e'(req_sel);
                pending  <= (src_e'(req_sel) != active);
            end else if (commit) begin
                active  <= target_q;
                pending <= 1'b0;
                done    <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sysclk_switch_ctrl.sv
// Module : sysclk_switch_ctrl
// Purpose: top of the system clock source switch controller; ties the
//          stable synchronizers, the select state machine and the enable
//          guard together.
// Assumes: a single controller clock that keeps running across switches;
//          synchronous active-low reset.
module sysclk_switch_ctrl
    import sysclk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_sel_valid,
    input  logic [SEL_W-1:0] sw_sel,
    input  logic             sw_irc_en,
    input  logic             sw_xosc_en,
    input  logic             sw_pll_en,
    input  logic             pll_ref_xosc,
    input  logic             irc_stable,
    input  logic             xosc_stable,
    input  logic             pll_stable,
    output logic             irc_en,
    output logic             xosc_en,
    output logic             pll_en,
    output logic [SEL_W-1:0] active_src,
    output logic             switch_pending,
    output logic             switch_done
);

    logic [NUM_SRC-1:0] stable_raw;
    logic [NUM_SRC-1:0] stable_sync;
    logic [NUM_SRC-1:0] sw_en;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] ready;
    src_e               active;

    // Gather per-source inputs into index-ordered vectors.
    always_comb begin
        stable_raw           = '0;
        stable_raw[IDX_IRC]  = irc_stable;
        stable_raw[IDX_XOSC] = xosc_stable;
        stable_raw[IDX_PLL]  = pll_stable;
        sw_en                = '0;
        sw_en[IDX_IRC]       = sw_irc_en;
        sw_en[IDX_XOSC]      = sw_xosc_en;
        sw_en[IDX_PLL]       = sw_pll_en;
    end

    sysclk_stable_sync #(
        .WIDTH  (NUM_SRC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (stable_raw),
        .sync_out (stable_sync)
    );

    // A source may be selected only when it runs and reports stable.
    assign ready = en_q & stable_sync;

    sysclk_select_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (sw_sel_valid),
        .req_sel   (sw_sel),
        .ready     (ready),
        .active    (active),
        .pending   (switch_pending),
        .done      (switch_done)
    );

    sysclk_enable_guard u_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .active       (active),
        .pll_ref_xosc (pll_ref_xosc),
        .sw_en        (sw_en),
        .en_q         (en_q)
    );

    assign active_src = active;
    assign irc_en     = en_q[IDX_IRC];
    assign xosc_en    = en_q[IDX_XOSC];
    assign pll_en     = en_q[IDX_PLL];

endmodule

// File: rtl/sysclk_switch_ctrl_sva.sv
// Module : sysclk_switch_ctrl_sva
// Purpose: port-level properties of the clock switch controller, bound to
//          every instance of the top module.
// Assumes: synchronous active-low reset; checks are disabled while it is low.
module sysclk_switch_ctrl_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       sw_sel_valid,
    input logic [1:0] sw_sel,
    input logic       sw_irc_en,
    input logic       pll_ref_xosc,
    input logic       irc_en,
    input logic       xosc_en,
    input logic       pll_en,
    input logic [1:0] active_src,
    input logic       switch_pending,
    input logic       switch_done
);

    assert_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        active_src != 2'b11);

    assert_bad_code_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_sel_valid && sw_sel == 2'b11 && !switch_pending) |=> !switch_pending);

    assert_target_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (switch_done && active_src == 2'b10) |-> $past(pll_en));

    assert_change_flags_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active_src != $past(active_src)) |-> switch_done);

    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        switch_done |=> !switch_done);

    assert_done_clears_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        switch_done |-> !switch_pending);

    assert_irc_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(active_src == 2'b00 || (active_src == 2'b10 && !pll_ref_xosc)) |-> irc_en);

    assert_xosc_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(active_src == 2'b01 || (active_src == 2'b10 && pll_ref_xosc)) |-> xosc_en);

    assert_pll_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(active_src == 2'b10) |-> pll_en);

    assert_sw_request_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sw_irc_en |=> irc_en);

endmodule

bind sysclk_switch_ctrl sysclk_switch_ctrl_sva u_sva (
    .clk            (clk),
    .rst_n          (rst_n),
    .sw_sel_valid   (sw_sel_valid),
    .sw_sel         (sw_sel),
    .sw_irc_en      (sw_irc_en),
    .pll_ref_xosc   (pll_ref_xosc),
    .irc_en         (irc_en),
    .xosc_en        (xosc_en),
    .pll_en         (pll_en),
    .active_src     (active_src),
    .switch_pending (switch_pending),
    .switch_done    (switch_done)
);

// File: tb/sysclk_switch_ctrl_tb_top.sv
// Bench: directed scenarios for the system clock switch controller.
module sysclk_switch_ctrl_tb_top;

    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sw_sel_valid;
    logic [1:0] sw_sel;
    logic       sw_irc_en, sw_xosc_en, sw_pll_en, pll_ref_xosc;
    logic       irc_stable, xosc_stable, pll_stable;
    logic       irc_en, xosc_en, pll_en;
    logic [1:0] active_src;
    logic       switch_pending, switch_done;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sysclk_switch_ctrl #(.SYNC_STAGES(SYNC)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .sw_sel_valid   (sw_sel_valid),
        .sw_sel         (sw_sel),
        .sw_irc_en      (sw_irc_en),
        .sw_xosc_en     (sw_xosc_en),
        .sw_pll_en      (sw_pll_en),
        .pll_ref_xosc   (pll_ref_xosc),
        .irc_stable     (irc_stable),
        .xosc_stable    (xosc_stable),
        .pll_stable     (pll_stable),
        .irc_en         (irc_en),
        .xosc_en        (xosc_en),
        .pll_en         (pll_en),
        .active_src     (active_src),
        .switch_pending (switch_pending),
        .switch_done    (switch_done)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic request(input logic [1:0] code);
        sw_sel_valid = 1'b1;
        sw_sel       = code;
        tick(1);
        sw_sel_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 active", {2'b0, active_src}, 4'h0);
        chk("R1 pending/done", {2'b0, switch_pending, switch_done}, 4'h0);
        chk("R1 enables pll/xosc/irc", {1'b0, pll_en, xosc_en, irc_en}, 4'h1);
        tick(1);
        chk("R1 after first edge enables", {1'b0, pll_en, xosc_en, irc_en}, 4'h1);
    endtask

    task automatic t_bad_code;
        request(2'b11);
        chk("R2 code 11 pending", {3'b0, switch_pending}, 4'h0);
        tick(1);
        chk("R2 code 11 active", {2'b0, active_src}, 4'h0);
    endtask

    task automatic t_same_source;
        request(2'b00);
        chk("R10 same source pending", {3'b0, switch_pending}, 4'h0);
        tick(1);
        chk("R10 same source no done", {3'b0, switch_done}, 4'h0);
    endtask

    task automatic t_wait_stable;
        sw_xosc_en = 1'b1;
        tick(2);
        request(2'b01);
        chk("R3 pending while unstable", {3'b0, switch_pending}, 4'h1);
        tick(3);
        chk("R3 old source kept", {2'b0, active_src}, 4'h0);
        xosc_stable = 1'b1;
        tick(SYNC);
        chk("R3 last cycle on old source", {2'b0, active_src, switch_pending}, 4'h1);
        tick(1);
        chk("R4 switched to external", {2'b0, active_src}, 4'h1);
        chk("R4 done high, pending low", {2'b0, switch_done, switch_pending}, 4'h2);
        tick(1);
        chk("R4 done lasts one cycle", {3'b0, switch_done}, 4'h0);
    endtask

    task automatic t_enable_logic;
        sw_xosc_en = 1'b0;
        tick(2);
        chk("R8 active external kept on", {3'b0, xosc_en}, 4'h1);
        sw_irc_en = 1'b0;
        tick(2);
        chk("R11 unprotected RC turns off", {3'b0, irc_en}, 4'h0);
        sw_irc_en = 1'b1;
        chk("R11 before edge still off", {3'b0, irc_en}, 4'h0);
        tick(1);
        chk("R11 one edge later on", {3'b0, irc_en}, 4'h1);
    endtask

    task automatic t_pll_disabled;
        pll_stable = 1'b1;
        tick(SYNC + 1);
        request(2'b10);
        tick(4);
        chk("R6 PLL disabled stays pending", {2'b0, active_src, switch_pending}, 4'h3);
    endtask

    task automatic t_latest_wins;
        request(2'b00);
        chk("R5 replaced request pending", {3'b0, switch_pending}, 4'h1);
        tick(1);
        chk("R5 latest target active", {2'b0, active_src}, 4'h0);
        chk("R5 done on switch", {3'b0, switch_done}, 4'h1);
        sw_pll_en = 1'b1;
        tick(3);
        chk("R5 old PLL target dropped", {2'b0, active_src, switch_pending}, 4'h0);
    endtask

    task automatic t_pll_protect;
        pll_ref_xosc = 1'b1;
        tick(1);
        request(2'b10);
        tick(1);
        chk("R4 switched to PLL", {2'b0, active_src, switch_done}, 4'h5);
        sw_pll_en  = 1'b0;
        sw_xosc_en = 1'b0;
        sw_irc_en  = 1'b0;
        tick(2);
        chk("R9 PLL kept on", {3'b0, pll_en}, 4'h1);
        chk("R8 external reference kept on", {3'b0, xosc_en}, 4'h1);
        chk("R11 RC not reference turns off", {3'b0, irc_en}, 4'h0);
        pll_ref_xosc = 1'b0;
        tick(2);
        chk("R7 RC reference kept on", {3'b0, irc_en}, 4'h1);
        chk("R8 external released", {3'b0, xosc_en}, 4'h0);
    endtask

    initial begin
        rst_n        = 1'b0;
        sw_sel_valid = 1'b0;
        sw_sel       = 2'b00;
        sw_irc_en    = 1'b0;
        sw_xosc_en   = 1'b0;
        sw_pll_en    = 1'b0;
        pll_ref_xosc = 1'b0;
        irc_stable   = 1'b1;
        xosc_stable  = 1'b0;
        pll_stable   = 1'b0;
        tick(3);
        rst_n = 1'b1;
        t_reset();
        sw_irc_en = 1'b1;
        t_bad_code();
        t_same_source();
        t_wait_stable();
        t_enable_logic();
        t_pll_disabled();
        t_latest_wins();
        t_pll_protect();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule